// File: doc/BRIEF.md
# Compare-Match Output Pin Driver

This block owns one output-compare flip-flop of a timer channel and decides what reaches the pin. The counter and comparator sit outside it. They send in a one-cycle compare-hit pulse, a flag that says whether the timer is in a PWM waveform class, and a one-cycle bottom/update pulse used by the PWM modes. A 2-bit output-mode field chooses what a hit does to the flip-flop. In the non-PWM class the choices are toggle, clear or set. In the PWM class the field picks non-inverted or inverted polarity.

When the mode field is nonzero, the flip-flop value replaces the general-purpose port data bit on the pin. The direction bit alone still decides whether the pin is driven. A force strobe applies the configured non-PWM action at once, as though a hit had occurred. A direct load input lets software place the flip-flop in a known state before the override is switched on.

All pins are plain control signals. No data flows through this block, so it has no valid/ready handshake and no back-pressure.

Top module: `ocu_pin_drive`

## Requirements
- R1: `pin_out` equals the output-compare state whenever either bit of `oc_mode` is 1, and equals `port_dout` when `oc_mode` is 00. This choice does not depend on `pwm_mode`.
- R2: `pin_oe` always equals `port_dir`, whether or not the override is active.
- R3: While `rst_n` is low and after reset, the output-compare state is 0.
- R4: With `oc_mode` = 00, no hit, bottom or force event changes the state, in either waveform class.
- R5: With `pwm_mode` = 0, a hit acts on the state as follows: `oc_mode` 01 toggles it, 10 clears it and 11 sets it. `pwm_bottom` has no effect in this class.
- R6: With `pwm_mode` = 1, the state changes as follows:
  - `oc_mode` 10 clears it on a hit and sets it on bottom.
  - `oc_mode` 11 sets it on a hit and clears it on bottom.
  - `oc_mode` 01 is no action.
  - When a hit and bottom arrive in the same cycle, the hit action wins.
- R7: Writing a new `oc_mode` without a hit leaves the state unchanged. The new action first applies at the next hit.
- R8: With `pwm_mode` = 0, `force_cmp` applies the configured action on that clock edge. If a hit arrives in the same cycle, the action is applied only once (a toggle flips the state a single time).
- R9: With `pwm_mode` = 1, `force_cmp` has no effect on the state.
- R10: `oc_load` writes `oc_load_val` into the state and takes priority over every hit, bottom and force event in the same cycle. It works while `oc_mode` = 00.
- R11: The state updates on the clock edge that samples the event. `pin_out` shows the new value after that edge, with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmp_hit | input | 1 | One-cycle compare-match pulse |
| pwm_mode | input | 1 | 1 = PWM waveform class, 0 = non-PWM |
| pwm_bottom | input | 1 | One-cycle bottom/update pulse (PWM class) |
| oc_mode | input | 2 | Output-mode field |
| force_cmp | input | 1 | One-cycle force strobe |
| oc_load | input | 1 | Direct load strobe for the state |
| oc_load_val | input | 1 | Value written by `oc_load` |
| port_dout | input | 1 | General-purpose port data bit |
| port_dir | input | 1 | Data-direction bit, 1 = output |
| pin_out | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pin output enable |

## Verification
Each of the three non-PWM actions is driven by a bare hit and again by the force strobe. This separates the toggle, clear and set encodings, and shows that the strobe enters the same action path. Hits and bottom pulses are run in both PWM polarities, including a hit and bottom in the same cycle, which shows which event has priority. Mode writes with no hit, and a force strobe in PWM mode, confirm that neither changes the state. The port bit and direction bit are then swept with the override both on and off, so that the pin mux is kept apart from the direction path.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    OCM_OFF  = 2'b00,
    OCM_ALT  = 2'b01,
    OCM_LOW  = 2'b10,
    OCM_HIGH = 2'b11
  } ocm_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_TOG  = 2'd1,
    ACT_CLR  = 2'd2,
    ACT_SET  = 2'd3
  } act_e;
endpackage

// File: rtl/ocu_action_decode.sv
module ocu_action_decode
  import ocu_pkg::*;
(
  input  logic              pwm_mode,
  input  logic              cmp_hit,
  input  logic              pwm_bottom,
  input  logic              force_cmp,
  input  logic [MODE_W-1:0] oc_mode,
  output act_e              act
);
  always_comb begin
    act = ACT_NONE;
    if (!pwm_mode) begin
      // Non-PWM class: a hit and the force strobe share one action path.
      if (cmp_hit || force_cmp) begin
        case (ocm_e'(oc_mode))
          OCM_ALT:  act = ACT_TOG;
          OCM_LOW:  act = ACT_CLR;
          OCM_HIGH: act = ACT_SET;
          default:  act = ACT_NONE;
        endcase
      end
    end else begin
      // PWM class: a hit has priority over bottom; force is not used here.
      if (cmp_hit) begin
        case (ocm_e'(oc_mode))
          OCM_LOW:  act = ACT_CLR;
          OCM_HIGH: act = ACT_SET;
          default:  act = ACT_NONE;
        endcase
      end else if (pwm_bottom) begin
        case (ocm_e'(oc_mode))
          OCM_LOW:  act = ACT_SET;
          OCM_HIGH: act = ACT_CLR;
          default:  act = ACT_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ocu_state_reg.sv
module ocu_state_reg
  import ocu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  input  logic ld,
  input  logic ld_val,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= 1'b0;
    else if (ld) q <= ld_val;
    else begin
      case (act)
        ACT_TOG: q <= ~q;
        ACT_CLR: q <= 1'b0;
        ACT_SET: q <= 1'b1;
        default: q <= q;
      endcase
    end
  end

  p_load_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (q == $past(ld_val)));
endmodule

// File: rtl/ocu_pin_mux.sv
module ocu_pin_mux
  import ocu_pkg::*;
(
  input  logic [MODE_W-1:0] oc_mode,
  input  logic              oc_q,
  input  logic              port_dout,
  input  logic              port_dir,
  output logic              pin_out,
  output logic              pin_oe
);
  logic take_over;
  assign take_over = |oc_mode;
  assign pin_out   = take_over ? oc_q : port_dout;
  assign pin_oe    = port_dir;
endmodule

// File: rtl/ocu_pin_drive.sv
module ocu_pin_drive
  import ocu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_hit,
  input  logic              pwm_mode,
  input  logic              pwm_bottom,
  input  logic [MODE_W-1:0] oc_mode,
  input  logic              force_cmp,
  input  logic              oc_load,
  input  logic              oc_load_val,
  input  logic              port_dout,
  input  logic              port_dir,
  output logic              pin_out,
  output logic              pin_oe
);
  act_e act;
  logic oc_q;

  ocu_action_decode u_dec (
    .pwm_mode  (pwm_mode),
    .cmp_hit   (cmp_hit),
    .pwm_bottom(pwm_bottom),
    .force_cmp (force_cmp),
    .oc_mode   (oc_mode),
    .act       (act)
  );

  ocu_state_reg u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .ld    (oc_load),
    .ld_val(oc_load_val),
    .q     (oc_q)
  );

  ocu_pin_mux u_mux (
    .oc_mode  (oc_mode),
    .oc_q     (oc_q),
    .port_dout(port_dout),
    .port_dir (port_dir),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe)
  );

  p_off_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_load && oc_mode == 2'b00) |=> $stable(oc_q));
  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_load && !pwm_mode && oc_mode == 2'b01 && (cmp_hit || force_cmp))
      |=> (oc_q != $past(oc_q)));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_load && !pwm_mode && oc_mode == 2'b10 && (cmp_hit || force_cmp)) |=> !oc_q);
  p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_load && !pwm_mode && oc_mode == 2'b11 && (cmp_hit || force_cmp)) |=> oc_q);
  p_pwm_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_load && pwm_mode && cmp_hit && oc_mode[1]) |=> (oc_q == $past(oc_mode[0])));
  p_pwm_force_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!oc_load && pwm_mode && force_cmp && !cmp_hit && !pwm_bottom) |=> $stable(oc_q));
endmodule

// File: tb/ocu_pin_drive_tb_top.sv
module ocu_pin_drive_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_hit = 0, pwm_mode = 0, pwm_bottom = 0, force_cmp = 0;
  logic oc_load = 0, oc_load_val = 0, port_dout = 0, port_dir = 0;
  logic [1:0] oc_mode = 2'b00;
  logic pin_out, pin_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic m_q = 1'b0;
  logic [1:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  ocu_pin_drive dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_hit(cmp_hit), .pwm_mode(pwm_mode),
    .pwm_bottom(pwm_bottom), .oc_mode(oc_mode), .force_cmp(force_cmp),
    .oc_load(oc_load), .oc_load_val(oc_load_val), .port_dout(port_dout),
    .port_dir(port_dir), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {pin_out,pin_oe} actual=%b expected=%b", tag, got, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, pushes the expected result.
  task automatic step(input logic c, input logic b, input logic f, input logic p,
                      input logic [1:0] m, input logic ld, input logic lv,
                      input logic pd, input logic dir, input string tag);
    logic nq;
    @(negedge clk);
    cmp_hit = c; pwm_bottom = b; force_cmp = f; pwm_mode = p; oc_mode = m;
    oc_load = ld; oc_load_val = lv; port_dout = pd; port_dir = dir;
    nq = m_q;
    if (ld) nq = lv;
    else if (!p) begin
      if (c || f) begin
        if (m == 2'b01) nq = ~m_q;
        else if (m == 2'b10) nq = 1'b0;
        else if (m == 2'b11) nq = 1'b1;
      end
    end else if (c) begin
      if (m == 2'b10) nq = 1'b0;
      else if (m == 2'b11) nq = 1'b1;
    end else if (b) begin
      if (m == 2'b10) nq = 1'b1;
      else if (m == 2'b11) nq = 1'b0;
    end
    m_q = nq;
    exp_q.push_back({(m != 2'b00) ? nq : pd, dir});
    tag_q.push_back(tag);
  endtask

  // Monitor: pops one expected item per clock, samples after the edge.
  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      #2;
      check(t, {pin_out, pin_oe}, e);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    oc_mode = 2'b11; port_dout = 1'b1; port_dir = 1'b1;
    @(posedge clk); #2;
    check("R3 reset state", {pin_out, pin_oe}, 2'b01);
    @(negedge clk); rst_n = 1'b1;
    //   c b f p mode ld lv pd dir
    step(0,0,0,0,2'b11,0,0,1,1,"R3 state 0 after reset");
    step(0,0,0,0,2'b00,0,0,1,1,"R1 port bit when mode 00");
    step(0,0,0,1,2'b00,0,0,0,0,"R2 dir low");
    step(1,1,1,0,2'b00,0,0,0,1,"R4 non-PWM mode 00 no change");
    step(1,1,0,1,2'b00,0,0,1,1,"R4 PWM mode 00 no change");
    step(0,0,0,0,2'b00,1,1,0,1,"R10 preload while override off");
    step(0,0,0,0,2'b11,0,0,0,1,"R1 override shows preloaded state");
    step(1,0,0,0,2'b10,0,0,1,1,"R5 clear on hit");
    step(0,0,0,0,2'b11,0,0,1,1,"R7 mode write without hit");
    step(1,0,0,0,2'b11,0,0,1,1,"R11 set on hit visible next edge");
    step(1,0,0,0,2'b01,0,0,0,1,"R5 toggle on hit");
    step(1,0,0,0,2'b01,0,0,0,1,"R5 toggle again");
    step(0,1,0,0,2'b01,0,0,0,1,"R5 bottom ignored non-PWM");
    step(0,0,1,0,2'b01,0,0,0,1,"R8 force toggles");
    step(1,0,1,0,2'b01,0,0,0,1,"R8 force+hit single toggle");
    step(0,0,1,0,2'b10,0,0,1,0,"R8 force clears");
    step(0,0,1,0,2'b11,0,0,0,1,"R8 force sets");
    step(1,0,0,0,2'b10,1,1,0,1,"R10 load beats hit");
    step(1,0,0,1,2'b10,0,0,0,1,"R6 non-inverted clear on hit");
    step(0,1,0,1,2'b10,0,0,0,1,"R6 non-inverted set at bottom");
    step(1,0,0,1,2'b11,0,0,0,1,"R6 inverted set on hit");
    step(0,1,0,1,2'b11,0,0,0,1,"R6 inverted clear at bottom");
    step(1,1,0,1,2'b11,0,0,0,1,"R6 hit beats bottom");
    step(1,1,0,1,2'b01,0,0,1,1,"R6 mode 01 reserved no action");
    step(0,0,1,1,2'b10,0,0,0,1,"R9 force ignored in PWM");
    step(0,0,0,1,2'b00,0,0,1,0,"R2 dir low with port bit");
    step(0,0,0,0,2'b10,0,0,1,0,"R2 dir low with override");
    step(0,0,0,0,2'b00,0,0,0,1,"R1 back to port bit");
    @(negedge clk);
    cmp_hit = 0; force_cmp = 0; pwm_bottom = 0; oc_load = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule